// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block runs single register transactions against an external PHY over a two-wire management link: a clock it drives, and one bidirectional data line that it drives through an output value and an output enable for a tri-state pad. The host pulses a start input with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then runs one complete frame. The frame is made of a 32-bit all-ones preamble, the header, the turnaround, 16 data bits and two trailing idle bits.

Every bit-time is three equal clock phases: low, high, low. Each phase lasts a parameterised number of system clock cycles. The default is 125 cycles, about 1 µs at 125 MHz, which is far longer than the minimum timing the link needs. On a read the block releases the data line for the acknowledge bit and the 16 data bits. It samples the input at the end of each of those bit-times. It always clocks all 16 data bits, even without an acknowledge, so that the PHY stays aligned. The host sees `busy` for the whole frame and a one-cycle `done` pulse when the frame ends.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy, done, the management clock, the data output, the output enable, the read data and the acknowledge flag are all 0. While no frame runs, the management clock and the output enable stay 0.
- R2: A start pulse seen while idle raises busy on the next clock cycle. Busy stays high until the last phase of the last idle bit ends. Done is high for exactly the one cycle in which busy first reads low.
- R3: Each bit-time is three phases of PHASE_CYC system cycles each: low, high, low. The data output and the output enable do not change while the clock is high, nor at its edges. A read frame therefore lasts 65*3*PHASE_CYC cycles and a write frame 66*3*PHASE_CYC cycles.
- R4: Every frame begins with 32 bit-times of data 1 with the output enable high.
- R5: The 14 header bits follow the preamble with the output enable high, each field sent MSB first. They are, in order: the start code 01, then the opcode (10 = read, 01 = write), then the 5-bit PHY address, then the 5-bit register address.
- R6: On a write, the header is followed by the turnaround pattern 1 then 0, then the 16 write-data bits MSB first, all with the output enable high.
- R7: On a read, the output enable is 0 for the 17 bit-times after the header. The first of these is the acknowledge bit. The acknowledge flag becomes 1 when the input sampled at the end of that bit-time is 0, and 0 otherwise.
- R8: On a read, the input is sampled at the end of the final low phase of each of the 16 data bit-times. The samples are shifted into the read data MSB first. All 16 bits are clocked and captured even when the acknowledge flag is 0.
- R9: Every frame ends with two idle bit-times of data 0 with the output enable high. A read frame is 65 clock pulses long and a write frame 66.
- R10: A start pulse while busy is ignored. The running frame keeps its bit stream and length, and no second frame follows it.
- R11: A write frame leaves the read data and the acknowledge flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only while idle |
| rd_i | input | 1 | 1 = read frame, 0 = write frame |
| phy_i | input | 5 | PHY address |
| reg_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Data captured by the last read |
| ack_ok_o | output | 1 | Last read saw an acknowledge (sampled 0) |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
Busy is due one cycle after the accepted start. Each clock pulse appears PHASE_CYC cycles into its bit-time. The frame occupies exactly bits*3*PHASE_CYC busy cycles, and done appears in the first cycle that busy reads low. The bench samples every output on the falling system clock edge. It captures the line value and the enable at each rising management clock, and it checks them again at the matching falling edge. It counts busy cycles and clock-high cycles against the totals computed from the frame length. The modelled PHY changes its input only at a rising management clock. That input is therefore settled well before the sample point at the end of the bit-time, and the captured read data and acknowledge are compared only after done.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   // Phase of one management bit-time
   typedef enum logic [1:0] {
      PH_LO1 = 2'd0,
      PH_HI  = 2'd1,
      PH_LO2 = 2'd2
   } phase_e;

   localparam logic [1:0] START_CODE = 2'b01;
   localparam logic [1:0] OP_READ    = 2'b10;
   localparam logic [1:0] OP_WRITE   = 2'b01;
   localparam logic [1:0] TA_WRITE   = 2'b10;

endpackage

// File: rtl/mdio_phase_tmr.sv
module mdio_phase_tmr #(
   parameter int PHASE_CYC = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic phase_end
);

   generate
      if (PHASE_CYC == 1) begin : g_single
         assign phase_end = run;
      end else begin : g_count
         localparam int CW = $clog2(PHASE_CYC);
         localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!run || cnt_q == LAST)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end

         assign phase_end = run && (cnt_q == LAST);

         // R3: the phase counter never passes its limit
         a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST);
         // R3: an idle timer restarts from zero
         a_r3_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift #(
   parameter int W = 66
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   output logic         msb
);

   logic [W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sr_q <= '0;
      else if (load)
         sr_q <= load_val;
      else if (shift)
         sr_q <= {sr_q[W-2:0], 1'b0};
   end

   assign msb = sr_q[W-1];

endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ack_en,
   input  logic              data_en,
   input  logic              din,
   output logic [DATA_W-1:0] rdata,
   output logic              ack_ok
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata  <= '0;
         ack_ok <= 1'b0;
      end else begin
         if (ack_en)
            ack_ok <= !din;
         if (data_en)
            rdata <= {rdata[DATA_W-2:0], din};
      end
   end

   // R11: result registers move only when a capture strobe is present
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_en && !data_en |=> $stable(rdata) && $stable(ack_ok));

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
   parameter int PHASE_CYC = 125,
   parameter int PRE_BITS  = 32,
   parameter int PHY_W     = 5,
   parameter int REG_W     = 5,
   parameter int DATA_W    = 16,
   parameter int IDLE_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              rd_i,
   input  logic [PHY_W-1:0]  phy_i,
   input  logic [REG_W-1:0]  reg_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              ack_ok_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              mdc_o,
   output logic              mdio_o,
   output logic              mdio_oe_o,
   input  logic              mdio_i
);
   import mdio_pkg::*;

   localparam int HDR_BITS = 4 + PHY_W + REG_W;
   localparam int ACK_BIT  = PRE_BITS + HDR_BITS;
   localparam int RD_BITS  = ACK_BIT + 1 + DATA_W + IDLE_BITS;
   localparam int WR_BITS  = ACK_BIT + 2 + DATA_W + IDLE_BITS;
   localparam int FRAME_W  = WR_BITS;
   localparam int PAD_W    = FRAME_W - PRE_BITS - HDR_BITS;
   localparam int CNT_W    = $clog2(FRAME_W + 1);

   localparam logic [CNT_W-1:0] ACK_IDX  = CNT_W'(ACK_BIT);
   localparam logic [CNT_W-1:0] DLST_IDX = CNT_W'(ACK_BIT + DATA_W);
   localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_BITS - 1);
   localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(WR_BITS - 1);

   generate
      if (PHASE_CYC < 1) begin : g_bad_phase
         $error("PHASE_CYC must be at least 1");
      end
      if (PRE_BITS < 1 || IDLE_BITS < 1) begin : g_bad_frame
         $error("PRE_BITS and IDLE_BITS must be at least 1");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
   endgenerate

   logic             busy_q;
   logic             done_q;
   logic             rd_q;
   phase_e           phase_q;
   logic [CNT_W-1:0] bit_q;
   logic             phase_end;
   logic             tx_msb;

   logic             accept;
   logic             bit_end;
   logic             frame_end;
   logic [CNT_W-1:0] last_idx;
   logic             in_rd_win;
   logic [FRAME_W-1:0] frame_vec;

   assign accept    = start_i && !busy_q;
   assign bit_end   = phase_end && (phase_q == PH_LO2);
   assign last_idx  = rd_q ? RD_LAST : WR_LAST;
   assign frame_end = bit_end && (bit_q == last_idx);
   assign in_rd_win = rd_q && (bit_q >= ACK_IDX) && (bit_q <= DLST_IDX);

   always_comb begin
      if (rd_i)
         frame_vec = {{PRE_BITS{1'b1}}, START_CODE, OP_READ, phy_i, reg_i,
                      {PAD_W{1'b0}}};
      else
         frame_vec = {{PRE_BITS{1'b1}}, START_CODE, OP_WRITE, phy_i, reg_i,
                      TA_WRITE, wdata_i, {IDLE_BITS{1'b0}}};
   end

   mdio_phase_tmr #(.PHASE_CYC(PHASE_CYC)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy_q),
      .phase_end (phase_end)
   );

   mdio_tx_shift #(.W(FRAME_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (frame_vec),
      .shift    (bit_end),
      .msb      (tx_msb)
   );

   mdio_rx_capture #(.DATA_W(DATA_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack_en  (bit_end && rd_q && (bit_q == ACK_IDX)),
      .data_en (bit_end && rd_q && (bit_q > ACK_IDX) && (bit_q <= DLST_IDX)),
      .din     (mdio_i),
      .rdata   (rdata_o),
      .ack_ok  (ack_ok_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         rd_q    <= 1'b0;
         phase_q <= PH_LO1;
         bit_q   <= '0;
      end else begin
         done_q <= frame_end;
         if (accept) begin
            busy_q  <= 1'b1;
            rd_q    <= rd_i;
            phase_q <= PH_LO1;
            bit_q   <= '0;
         end else if (busy_q && phase_end) begin
            unique case (phase_q)
               PH_LO1:  phase_q <= PH_HI;
               PH_HI:   phase_q <= PH_LO2;
               default: begin
                  phase_q <= PH_LO1;
                  if (frame_end)
                     busy_q <= 1'b0;
                  else
                     bit_q <= bit_q + 1'b1;
               end
            endcase
         end
      end
   end

   assign busy_o    = busy_q;
   assign done_o    = done_q;
   assign mdc_o     = busy_q && (phase_q == PH_HI);
   assign mdio_o    = busy_q && tx_msb;
   assign mdio_oe_o = busy_q && !in_rd_win;

   // R1: nothing toggles on the link while idle
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !mdc_o && !mdio_oe_o);
   // R2: a frame only begins from a start pulse
   a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(start_i));
   // R2: done marks the cycle right after the frame
   a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q && $past(busy_q));
   // R3: line value steady across the rising clock
   a_r3_stable_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc_o) |-> $stable(mdio_o) && $stable(mdio_oe_o));
   // R3: line value steady across the falling clock
   a_r3_stable_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mdc_o) |-> $stable(mdio_o) && $stable(mdio_oe_o));
   // R10: a start during a frame does not disturb it
   a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && start_i && !frame_end |=> busy_q && $stable(rd_q));

endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;

   localparam int PC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        rd_i = 1'b0;
   logic [4:0]  phy_i = '0;
   logic [4:0]  reg_i = '0;
   logic [15:0] wdata_i = '0;
   logic [15:0] rdata_o;
   logic        ack_ok_o, busy_o, done_o, mdc_o, mdio_o, mdio_oe_o;
   logic        mdio_i = 1'b1;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   mdio_master #(.PHASE_CYC(PC)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
      .phy_i(phy_i), .reg_i(reg_i), .wdata_i(wdata_i),
      .rdata_o(rdata_o), .ack_ok_o(ack_ok_o), .busy_o(busy_o),
      .done_o(done_o), .mdc_o(mdc_o), .mdio_o(mdio_o),
      .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   // expected {oe, value} of bit-time b
   function automatic logic [1:0] exp_bit(bit rd, logic [4:0] phy, logic [4:0] ra,
                                          logic [15:0] wd, int b);
      logic [13:0] hdr;
      hdr = {2'b01, (rd ? 2'b10 : 2'b01), phy, ra};
      if (b < 32) return 2'b11;
      if (b < 46) return {1'b1, hdr[13-(b-32)]};
      if (rd) begin
         if (b <= 62) return 2'b00;
         return 2'b10;
      end
      if (b == 46) return 2'b11;
      if (b == 47) return 2'b10;
      if (b <= 63) return {1'b1, wd[15-(b-48)]};
      return 2'b10;
   endfunction

   task automatic run_frame(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                            input logic [15:0] wd, input logic [15:0] resp,
                            input bit ack_low, input bit inject);
      logic cap_o [0:79];
      logic cap_oe [0:79];
      int rises = 0, hi_cyc = 0, busy_cyc = 0, unstable = 0;
      int e_pre = 0, e_hdr = 0, e_win = 0, e_pay = 0, e_idle = 0;
      int nbits;
      logic prev_mdc = 1'b0;
      logic [1:0] e;
      nbits = rd ? 65 : 66;
      @(negedge clk);
      start_i = 1'b1; rd_i = rd; phy_i = phy; reg_i = ra; wdata_i = wd;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R2 busy one cycle after start", int'(busy_o), 1);
      while (busy_o) begin
         busy_cyc++;
         if (inject && busy_cyc == 100) begin
            start_i = 1'b1; rd_i = ~rd; phy_i = ~phy; wdata_i = ~wd;
         end else begin
            start_i = 1'b0;
         end
         if (mdc_o) hi_cyc++;
         if (mdc_o && !prev_mdc) begin
            if (rises < 80) begin
               cap_o[rises] = mdio_o;
               cap_oe[rises] = mdio_oe_o;
            end
            if (rd && rises == 46) mdio_i = ack_low ? 1'b0 : 1'b1;
            else if (rd && rises >= 47 && rises <= 62) mdio_i = resp[15-(rises-47)];
            else mdio_i = 1'b1;
            rises++;
         end
         if (!mdc_o && prev_mdc && rises > 0 && rises <= 80) begin
            if (mdio_o !== cap_o[rises-1] || mdio_oe_o !== cap_oe[rises-1]) unstable++;
         end
         prev_mdc = mdc_o;
         @(negedge clk);
      end
      start_i = 1'b0;
      chk(done_o == 1'b1, "R2 done in first idle cycle", int'(done_o), 1);
      for (int b = 0; b < nbits && b < 80; b++) begin
         e = exp_bit(rd, phy, ra, wd, b);
         if ((cap_oe[b] !== e[1]) || (e[1] && cap_o[b] !== e[0])) begin
            if (b < 32) e_pre++;
            else if (b < 46) e_hdr++;
            else if (rd && b <= 62) e_win++;
            else if (!rd && b <= 63) e_pay++;
            else e_idle++;
         end
      end
      chk(rises == nbits, "R9 frame pulse count", rises, nbits);
      chk(busy_cyc == nbits*3*PC, "R3 frame busy cycles", busy_cyc, nbits*3*PC);
      chk(hi_cyc == nbits*PC, "R3 clock high cycles", hi_cyc, nbits*PC);
      chk(unstable == 0, "R3 line stable while clock high", unstable, 0);
      chk(e_pre == 0, "R4 preamble bits", e_pre, 0);
      chk(e_hdr == 0, "R5 header bits", e_hdr, 0);
      if (rd) chk(e_win == 0, "R7 released window", e_win, 0);
      else    chk(e_pay == 0, "R6 turnaround and data bits", e_pay, 0);
      chk(e_idle == 0, "R9 idle bits", e_idle, 0);
      @(negedge clk);
      chk(done_o == 1'b0, "R2 done lasts one cycle", int'(done_o), 0);
      if (inject) begin
         repeat (3 * PC) @(negedge clk);
         chk(busy_o == 1'b0, "R10 no second frame after ignored start", int'(busy_o), 0);
      end
      mdio_i = 1'b1;
   endtask

   task automatic t_reset();
      chk(busy_o == 0 && done_o == 0, "R1 busy/done after reset", {busy_o, done_o}, 0);
      chk(mdc_o == 0 && mdio_o == 0 && mdio_oe_o == 0, "R1 link outputs after reset",
          {mdc_o, mdio_o, mdio_oe_o}, 0);
      chk(rdata_o == 16'h0 && ack_ok_o == 0, "R1 read results after reset",
          {ack_ok_o, rdata_o}, 0);
   endtask

   task automatic t_write();
      run_frame(1'b0, 5'h01, 5'h00, 16'hA55A, 16'h0, 1'b0, 1'b0);
   endtask

   task automatic t_read_ack();
      run_frame(1'b1, 5'h1F, 5'h1F, 16'h0, 16'h8001, 1'b1, 1'b0);
      chk(ack_ok_o == 1'b1, "R7 ack seen", int'(ack_ok_o), 1);
      chk(rdata_o == 16'h8001, "R8 read data", rdata_o, 16'h8001);
   endtask

   task automatic t_read_noack();
      run_frame(1'b1, 5'h00, 5'h0A, 16'h0, 16'hFFFF, 1'b0, 1'b0);
      chk(ack_ok_o == 1'b0, "R7 no ack", int'(ack_ok_o), 0);
      chk(rdata_o == 16'hFFFF, "R8 all bits clocked without ack", rdata_o, 16'hFFFF);
   endtask

   task automatic t_write_keeps();
      run_frame(1'b1, 5'h12, 5'h05, 16'h0, 16'h3C96, 1'b1, 1'b0);
      chk(rdata_o == 16'h3C96, "R8 read data pattern", rdata_o, 16'h3C96);
      run_frame(1'b0, 5'h12, 5'h05, 16'hFFFF, 16'h0, 1'b0, 1'b0);
      chk(rdata_o == 16'h3C96 && ack_ok_o == 1'b1, "R11 write leaves read results",
          {ack_ok_o, rdata_o}, {1'b1, 16'h3C96});
   endtask

   task automatic t_busy_ignore();
      run_frame(1'b0, 5'h0C, 5'h13, 16'h1234, 16'h0, 1'b0, 1'b1);
      run_frame(1'b1, 5'h03, 5'h1C, 16'h0, 16'h0000, 1'b1, 1'b1);
      chk(rdata_o == 16'h0000 && ack_ok_o == 1'b1, "R10 read result after ignored start",
          {ack_ok_o, rdata_o}, {1'b1, 16'h0000});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_write();
      t_read_ack();
      t_read_noack();
      t_write_keeps();
      t_busy_ignore();
      repeat (4) @(negedge clk);
      summary();
      $finish;
   end

endmodule